// File: doc/BRIEF.md
# Three-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address as wide as 52 bits. It does this by reading entries from a three-level tree of translation tables held in memory. A base register supplies the location of the top table. The top table is small and has only four slots. Each of its entries leads to a directory, each directory entry leads to a leaf table, and each leaf entry names the 4 KiB page frame that holds the data.

A client hands over one virtual address at a time through a valid/ready handshake. The walker then issues 64-bit entry reads, one at a time, on a request/response memory port whose response latency is not fixed. The walk ends in one of two ways. It produces the physical address, or it reports a fault together with the level whose entry was not present. The result stays on the output until the client takes it. Translation happens only while the enable bit of the control word is set. When that bit is clear, the address passes straight through to the output.

Top module: `xw_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1 while `rsp_valid_o` and `mem_req_valid_o` are both 0.
- R2: If bit 5 of `ctrl_i` is 0 when a request is accepted, the result is the virtual address zero-extended to 52 bits, with `rsp_fault_o` = 0 and no memory read. Every other bit of `ctrl_i` has no effect.
- R3: With bit 5 set, the walker makes up to three reads in a fixed order. The first is at root + va[31:30]*8. The second is at dir_base + va[29:21]*8. The third is at tbl_base + va[20:12]*8.
- R4: At most one memory read is outstanding at any time. A new read is requested only after the previous response has arrived.
- R5: In each 64-bit entry, bits [51:12] give the next table base or the final frame. Bits [63:52] and [11:1] are ignored. The physical address is the final frame followed by va[11:0].
- R6: When bit 0 (present) of an entry is 0, the walk stops with no further reads. The result then has `rsp_fault_o` = 1 and `rsp_level_o` set to the failing level: 0 for the top table, 1 for a directory, 2 for a leaf table.
- R7: A request is accepted only when the walker is idle. `req_ready_o` stays 0 from the moment a request is accepted until its result has been taken.
- R8: Once `rsp_valid_o` rises, it stays high and the result stays unchanged until `rsp_ready_i` is seen high.
- R9: A pending memory read keeps `mem_req_valid_o` high and `mem_req_addr_o` stable until `mem_req_ready_i` accepts it.
- R10: Any number of cycles may pass between a read being accepted and its response arriving, and any number may pass before the read is accepted. The result does not depend on either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 32 | Control word; bit 5 enables translation |
| root_base_i | input | 52 | Byte address of the four-slot top table (8-byte aligned) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| rsp_valid_o | output | 1 | Result available |
| rsp_ready_i | input | 1 | Client takes the result |
| rsp_paddr_o | output | 52 | Physical address (valid when no fault) |
| rsp_fault_o | output | 1 | Walk ended on a not-present entry |
| rsp_level_o | output | 2 | Level of the not-present entry |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 52 | Byte address of the 64-bit entry to read |
| mem_rsp_valid_i | input | 1 | Entry read data valid |
| mem_rsp_data_i | input | 64 | Entry read data |

## Verification
The hardest case to reach from the ports is a walk that stops at a directory or a leaf table after earlier levels succeeded. That has to happen while the memory is slowly accepting reads or returning responses late, and while the client is holding off on taking the result. To produce it, the bench models memory arithmetically. Entries are marked absent at fixed index residues in every directory and table, and every entry also carries noise in its ignored bits. A sweep over the top index, selected directory indices and selected leaf indices then hits absent entries at each level. Random request-accept delays, response latencies and result-accept delays are applied on every walk.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int VA_W         = 32;
    localparam int PA_W         = 52;
    localparam int ENT_W        = 64;
    localparam int OFF_W        = 12;
    localparam int IDX_W        = 9;
    localparam int TOP_IDX_W    = 2;
    localparam int LVL_N        = 3;
    localparam int LVL_W        = 2;
    localparam int SLOT_SHIFT   = 3;
    localparam int CTRL_W       = 32;
    localparam int XLAT_EN_BIT  = 5;
    localparam int PRESENT_BIT  = 0;
    localparam int FRAME_W      = PA_W - OFF_W;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_ISSUE,
        WS_AWAIT,
        WS_REPLY
    } walk_st_e;

    typedef struct packed {
        logic [PA_W-1:0]  paddr;
        logic             fault;
        logic [LVL_W-1:0] level;
    } xlat_res_t;

    typedef struct packed {
        logic            present;
        logic [PA_W-1:0] base;
    } ent_info_t;

    function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
        return base + {{(PA_W-IDX_W-SLOT_SHIFT){1'b0}}, idx, {SLOT_SHIFT{1'b0}}};
    endfunction
endpackage

// File: rtl/xw_idx_sel.sv
module xw_idx_sel
    import xw_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] fld [LVL_N];

    for (genvar l = 0; l < LVL_N; l++) begin : g_fld
        localparam int W  = (l == 0) ? TOP_IDX_W : IDX_W;
        localparam int LO = OFF_W + (LVL_N - 1 - l) * IDX_W;
        assign fld[l] = IDX_W'(vaddr[LO +: W]);
    end

    always_comb begin
        idx = '0;
        for (int l = 0; l < LVL_N; l++) begin
            if (level == LVL_W'(l)) idx = fld[l];
        end
    end

    logic unused_off;
    assign unused_off = ^vaddr[OFF_W-1:0];
endmodule

// File: rtl/xw_entry_dec.sv
module xw_entry_dec
    import xw_pkg::*;
(
    input  logic [ENT_W-1:0] ent,
    output ent_info_t        info
);
    assign info.present = ent[PRESENT_BIT];
    assign info.base    = {ent[PA_W-1:OFF_W], {OFF_W{1'b0}}};

    logic unused_ent;
    assign unused_ent = ^{ent[ENT_W-1:PA_W], ent[OFF_W-1:PRESENT_BIT+1]};
endmodule

// File: rtl/xw_walk_ctl.sv
module xw_walk_ctl
    import xw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             xlat_on,
    input  logic [PA_W-1:0]  root_base,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [VA_W-1:0]  req_vaddr_i,
    output logic             rsp_valid_o,
    input  logic             rsp_ready_i,
    output xlat_res_t        res_o,
    output logic             mem_req_valid_o,
    input  logic             mem_req_ready_i,
    input  logic             mem_rsp_valid_i,
    input  ent_info_t        ent_info,
    output logic [VA_W-1:0]  walk_va,
    output logic [LVL_W-1:0] walk_lvl,
    output logic [PA_W-1:0]  walk_base
);
    walk_st_e          st_q;
    logic [VA_W-1:0]   va_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [PA_W-1:0]   base_q;
    xlat_res_t         res_q;

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LVL_N - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WS_IDLE;
            va_q   <= '0;
            lvl_q  <= '0;
            base_q <= '0;
            res_q  <= '0;
        end else begin
            unique case (st_q)
                WS_IDLE: begin
                    if (req_valid_i) begin
                        va_q   <= req_vaddr_i;
                        lvl_q  <= '0;
                        base_q <= root_base;
                        if (xlat_on) begin
                            st_q <= WS_ISSUE;
                        end else begin
                            res_q.paddr <= PA_W'(req_vaddr_i);
                            res_q.fault <= 1'b0;
                            res_q.level <= '0;
                            st_q        <= WS_REPLY;
                        end
                    end
                end
                WS_ISSUE: begin
                    if (mem_req_ready_i) st_q <= WS_AWAIT;
                end
                WS_AWAIT: begin
                    if (mem_rsp_valid_i) begin
                        if (!ent_info.present) begin
                            res_q.paddr <= '0;
                            res_q.fault <= 1'b1;
                            res_q.level <= lvl_q;
                            st_q        <= WS_REPLY;
                        end else if (lvl_q == LAST_LVL) begin
                            res_q.paddr <= {ent_info.base[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
                            res_q.fault <= 1'b0;
                            res_q.level <= lvl_q;
                            st_q        <= WS_REPLY;
                        end else begin
                            lvl_q  <= lvl_q + 1'b1;
                            base_q <= ent_info.base;
                            st_q   <= WS_ISSUE;
                        end
                    end
                end
                WS_REPLY: begin
                    if (rsp_ready_i) st_q <= WS_IDLE;
                end
                default: st_q <= WS_IDLE;
            endcase
        end
    end

    assign req_ready_o     = (st_q == WS_IDLE);
    assign rsp_valid_o     = (st_q == WS_REPLY);
    assign mem_req_valid_o = (st_q == WS_ISSUE);
    assign res_o           = res_q;
    assign walk_va         = va_q;
    assign walk_lvl        = lvl_q;
    assign walk_base       = base_q;

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(res_o)); // R8

    AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o); // R9

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req_valid_o) |-> $past(mem_rsp_valid_i) || $past(req_valid_i && req_ready_o)); // R4

    AST_FAULT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o && res_o.fault |-> res_o.level < LVL_W'(LVL_N)); // R6

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        req_valid_i && req_ready_o |=> !req_ready_o); // R7

    AST_PASS_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid_i && req_ready_o && !xlat_on) |-> rsp_valid_o && !res_o.fault); // R2
endmodule

// File: rtl/xw_walker.sv
module xw_walker
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [PA_W-1:0]   root_base_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [VA_W-1:0]   req_vaddr_i,
    output logic              rsp_valid_o,
    input  logic              rsp_ready_i,
    output logic [PA_W-1:0]   rsp_paddr_o,
    output logic              rsp_fault_o,
    output logic [LVL_W-1:0]  rsp_level_o,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [PA_W-1:0]   mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [ENT_W-1:0]  mem_rsp_data_i
);
    logic             xlat_on;
    ent_info_t        ent_info;
    xlat_res_t        res;
    logic [VA_W-1:0]  walk_va;
    logic [LVL_W-1:0] walk_lvl;
    logic [PA_W-1:0]  walk_base;
    logic [IDX_W-1:0] slot_idx;

    assign xlat_on = ctrl_i[XLAT_EN_BIT];

    logic unused_ctrl;
    assign unused_ctrl = ^{ctrl_i[CTRL_W-1:XLAT_EN_BIT+1], ctrl_i[XLAT_EN_BIT-1:0]};

    xw_idx_sel idx_sel_i (
        .vaddr (walk_va),
        .level (walk_lvl),
        .idx   (slot_idx)
    );

    xw_entry_dec entry_dec_i (
        .ent  (mem_rsp_data_i),
        .info (ent_info)
    );

    xw_walk_ctl walk_ctl_i (
        .clk             (clk),
        .rst             (rst),
        .xlat_on         (xlat_on),
        .root_base       (root_base_i),
        .req_valid_i     (req_valid_i),
        .req_ready_o     (req_ready_o),
        .req_vaddr_i     (req_vaddr_i),
        .rsp_valid_o     (rsp_valid_o),
        .rsp_ready_i     (rsp_ready_i),
        .res_o           (res),
        .mem_req_valid_o (mem_req_valid_o),
        .mem_req_ready_i (mem_req_ready_i),
        .mem_rsp_valid_i (mem_rsp_valid_i),
        .ent_info        (ent_info),
        .walk_va         (walk_va),
        .walk_lvl        (walk_lvl),
        .walk_base       (walk_base)
    );

    assign mem_req_addr_o = slot_addr(walk_base, slot_idx);
    assign rsp_paddr_o    = res.paddr;
    assign rsp_fault_o    = res.fault;
    assign rsp_level_o    = res.level;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o && !mem_req_ready_i |=> $stable(mem_req_addr_o)); // R9

    AST_NO_READ_WHILE_REPLY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |-> !mem_req_valid_o && !req_ready_o); // R7
endmodule

// File: tb/xw_walker_tb.sv
module xw_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ctrl = '0;
    logic [51:0] root_base;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [51:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_level;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    localparam logic [51:0] ROOT = 52'h0_0000_0001_2340;
    localparam logic [51:0] DIRB = 52'h0_0000_0800_0000;
    localparam logic [51:0] TBLB = 52'h0_0010_0000_0000;

    int tests = 0;
    int fails = 0;
    int rd_cnt = 0;
    bit finished = 0;
    logic [51:0] exp_addr [3];

    assign root_base = ROOT;

    always #5 clk = ~clk;

    xw_walker dut_i (
        .clk(clk), .rst(rst), .ctrl_i(ctrl), .root_base_i(root_base),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
        .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_paddr_o(rsp_paddr),
        .rsp_fault_o(rsp_fault), .rsp_level_o(rsp_level),
        .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
        .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
        .mem_rsp_data_i(mem_rsp_data)
    );

    function automatic logic [39:0] frame_of(input int n, input int k);
        return 40'hC0_0000_0000 | 40'(n * 512 + k);
    endfunction

    function automatic logic [63:0] mem_word(input logic [51:0] a);
        logic [51:0] nb;
        logic        pres;
        int i, j, k, n;
        nb = '0;
        pres = 1'b0;
        if (a >= ROOT && a < ROOT + 52'd32) begin
            i = int'((a - ROOT) >> 3);
            nb = DIRB + 52'(i) * 52'd4096;
            pres = (i != 3);
        end else if (a >= DIRB && a < DIRB + 52'd12288) begin
            i = int'((a - DIRB) >> 12);
            j = int'(a[11:3]);
            n = i * 512 + j;
            nb = TBLB + 52'(n) * 52'd4096;
            pres = (j % 5 != 3);
        end else if (a >= TBLB && a < TBLB + 52'(1536 * 4096)) begin
            n = int'((a - TBLB) >> 12);
            k = int'(a[11:3]);
            nb = {frame_of(n, k), 12'h000};
            pres = (k % 7 != 4);
        end else begin
            return 64'h0;
        end
        return {12'hABC, nb[51:12], 11'h073, pres};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder: random accept delay and response latency
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (!rst && mem_req_valid) begin
                logic [51:0] a;
                int d;
                int lat;
                a = mem_req_addr;
                d = int'($urandom % 4);
                for (int w = 0; w < d; w++) begin
                    @(negedge clk);
                    check(mem_req_valid && mem_req_addr == a, "R9 request hold",
                          {11'h0, mem_req_valid, mem_req_addr}, {11'h0, 1'b1, a});
                end
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                if (rd_cnt < 3)
                    check(a == exp_addr[rd_cnt], "R3 entry address", {12'h0, a}, {12'h0, exp_addr[rd_cnt]});
                else
                    check(1'b0, "R6 extra read", {12'h0, a}, 64'h0);
                rd_cnt++;
                lat = int'($urandom % 5);
                for (int w = 0; w < lat; w++) begin
                    @(negedge clk);
                    check(!mem_req_valid, "R4 one outstanding", {63'h0, mem_req_valid}, 64'h0);
                end
                mem_rsp_data = mem_word(a);
                mem_rsp_valid = 1'b1;
            end
        end
    end

    task automatic run_walk(input logic [31:0] c, input logic [31:0] va,
                            input bit exp_fault, input logic [1:0] exp_lvl,
                            input logic [51:0] exp_pa, input int exp_reads, input string tag);
        int hold;
        bit stable_ok;
        logic [51:0] pa0;
        logic f0;
        logic [1:0] l0;
        @(negedge clk);
        rd_cnt = 0;
        ctrl = c;
        req_vaddr = va;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = 32'h5A5A_5A5A;
        ctrl = ~c;
        while (!rsp_valid) @(negedge clk);
        if (exp_fault)
            check(rsp_fault && rsp_level == exp_lvl, {tag, " R6 fault level"},
                  {61'h0, rsp_fault, rsp_level}, {61'h0, 1'b1, exp_lvl});
        else
            check(!rsp_fault && rsp_paddr == exp_pa, {tag, " R5 R10 physical address"},
                  {11'h0, rsp_fault, rsp_paddr}, {12'h0, exp_pa});
        check(rd_cnt == exp_reads, {tag, " R6 read count"}, 64'(rd_cnt), 64'(exp_reads));
        pa0 = rsp_paddr;
        f0 = rsp_fault;
        l0 = rsp_level;
        stable_ok = 1'b1;
        hold = int'($urandom % 4);
        for (int w = 0; w < hold; w++) begin
            @(negedge clk);
            if (!rsp_valid || req_ready || rsp_paddr != pa0 || rsp_fault != f0 || rsp_level != l0)
                stable_ok = 1'b0;
        end
        check(stable_ok, {tag, " R8 R7 result hold"}, {63'h0, stable_ok}, 64'h1);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(!rsp_valid && req_ready, {tag, " R7 back to idle"}, {62'h0, rsp_valid, req_ready}, 64'h1);
    endtask

    task automatic xlat_walk(input logic [31:0] c, input int i, input int j, input int k, input int off);
        logic [31:0] va;
        int n;
        bit f;
        logic [1:0] lv;
        int nr;
        n = i * 512 + j;
        va = {i[1:0], j[8:0], k[8:0], off[11:0]};
        exp_addr[0] = ROOT + 52'(i) * 52'd8;
        exp_addr[1] = DIRB + 52'(i) * 52'd4096 + 52'(j) * 52'd8;
        exp_addr[2] = TBLB + 52'(n) * 52'd4096 + 52'(k) * 52'd8;
        f = 1'b1;
        if (i == 3)           begin lv = 2'd0; nr = 1; end
        else if (j % 5 == 3)  begin lv = 2'd1; nr = 2; end
        else if (k % 7 == 4)  begin lv = 2'd2; nr = 3; end
        else                  begin f = 1'b0; lv = 2'd0; nr = 3; end
        run_walk(c, va, f, lv, {frame_of(n, k), off[11:0]}, nr, "xlat");
    endtask

    initial begin
        int jl [6];
        int kl [5];
        logic [31:0] pv [5];
        jl = '{0, 1, 3, 8, 255, 511};
        kl = '{0, 4, 5, 11, 511};
        pv = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_1234, 32'h4020_1FFF, 32'hC3A5_0007};
        repeat (3) @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req_valid, "R1 reset state",
              {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req_valid, "R1 idle after reset",
              {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);
        // R2 pass-through, other control bits set
        for (int p = 0; p < 5; p++) begin
            run_walk(32'hFFFF_FFDF, pv[p], 1'b0, 2'd0, {20'h0, pv[p]}, 0, "R2 pass");
            run_walk(32'h0000_0000, pv[p], 1'b0, 2'd0, {20'h0, pv[p]}, 0, "R2 pass zero ctrl");
        end
        // R3 R5 R6 R10 sweep
        for (int i = 0; i < 4; i++)
            for (int a = 0; a < 6; a++)
                for (int b = 0; b < 5; b++)
                    xlat_walk(((a + b) % 2 == 0) ? 32'h0000_0020 : 32'hFFFF_FFFF,
                              i, jl[a], kl[b], (i * 1237 + a * 311 + b * 97) % 4096);
        // enable toggling between walks
        xlat_walk(32'h0000_0020, 1, 2, 3, 12'hFFF);
        run_walk(32'h0000_0010, 32'h7FFF_0000, 1'b0, 2'd0, 52'h0_0000_7FFF_0000, 0, "R2 toggle");
        xlat_walk(32'h0000_0020, 2, 510, 510, 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule